// File: doc/BRIEF.md
# Structure Load-Replicate Unit

This block carries out a vector "load one structure, copy it to all lanes" operation. A single `start` pulse captures the operation:

- the structure size n (1 to 4 elements);
- the element width (8, 16 or 32 bits);
- the spacing between destination registers (1 or 2);
- the first destination register;
- a pair flag, which lets a one-element load fill two consecutive registers;
- an optional alignment hint;
- the general-register indices of the base and of the offset;
- the base address and the offset value;
- a base-update mode.

The block checks the encoding and the alignment in the cycle after `start`. A rejected operation ends there with a flag and the `done` pulse. It issues no memory request and writes no register.

A legal operation fetches its n elements in order, one request at a time, on a valid/ready request channel. The response channel returns each element little-endian in the low bits of `mem_rsp_data`. A request is held, address and size unchanged, until `mem_req_ready` is seen high. The block takes at most one response per request and raises `mem_rsp_ready` only while it waits for that response. After each element arrives, the block writes one 64-bit register in which every lane is a copy of the element. When the last write is done, it updates the base as the mode asks and pulses `done`.

Top module: `ldrep_unit`

## Requirements
- R1: One cycle after `start`, `illegal` and `done` are both high for one cycle if any of the following holds. No memory request and no register write follow. The conditions are: `op_esize` = 3; `op_wb` = 3; `base_idx` = 15; `op_wb` = 2 with `off_idx` 13 or 15; `op_pair` set with `op_count` not 0; or the last register touched is above 31. The last register is `op_dreg`+1 with the pair flag, and otherwise `op_dreg` + (n-1)×spacing.
- R2: `op_hint` codes are 0 none, 1 = 1 byte, 2 = 2, 3 = 4, 4 = 8, 5 = 16; codes 6 and 7 are never legal. The allowed nonzero hints depend on n:
  - n=1: 2 bytes with 16-bit elements, or 4 bytes with 32-bit elements.
  - n=2: only the hint equal to the element size.
  - n=3: none.
  - n=4: 4 bytes for 8-bit elements, 8 bytes for 16-bit, and 8 or 16 bytes for 32-bit.
  
  Any other nonzero hint is illegal as in R1.
- R3: A legal operation whose base is not a multiple of the hinted size raises `align_fault` and `done` one cycle after `start`, with no request and no write. With no hint, the required size is the element size. `illegal` takes precedence.
- R4: Element k is requested at base + k×element bytes, with `mem_req_size` = log2(element bytes). The request stays valid with a stable address until accepted.
- R5: Every byte lane j (0..7) of `wr_data` equals the memory byte at element address + (j mod element bytes).
- R6: Element k is written to register `op_dreg` + k×spacing, where `op_stride` 0 gives spacing 1 and 1 gives spacing 2. With the pair flag, the single element is written to `op_dreg` and then `op_dreg`+1.
- R7: `op_wb` = 1 sets `base_out` to base + n×element bytes, shown together with `done` and `base_wb_valid` after the last write.
- R8: `op_wb` = 2 sets `base_out` to base + `off_val`, while all requests use the original base.
- R9: `op_wb` = 0, and every rejected operation, leave `base_out` unchanged with `base_wb_valid` low.
- R10: `start` while an operation is in progress is ignored and does not alter its results.
- R11: After reset all outputs are low. `done` lasts exactly one cycle per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_count | input | 2 | Structure size n minus one |
| op_esize | input | 2 | Element width: 0=8, 1=16, 2=32 bits |
| op_stride | input | 1 | Register spacing: 0=1, 1=2 |
| op_pair | input | 1 | One-element load into two consecutive registers |
| op_dreg | input | 5 | First destination register |
| op_hint | input | 3 | Alignment hint code |
| op_wb | input | 2 | Base update: 0 none, 1 by size, 2 by offset register |
| base_idx | input | 4 | General-register index of the base |
| off_idx | input | 4 | General-register index of the offset |
| base_addr | input | 32 | Base address |
| off_val | input | 32 | Offset register value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_size | output | 2 | log2 of bytes to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waiting for read data |
| mem_rsp_data | input | 32 | Read data, little-endian, element in low bits |
| wr_valid | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register write index |
| wr_data | output | 64 | Replicated register value |
| done | output | 1 | Operation finished (one cycle) |
| illegal | output | 1 | Illegal encoding |
| align_fault | output | 1 | Alignment fault |
| base_wb_valid | output | 1 | Base update presented on base_out |
| base_out | output | 32 | Updated base value |

## Verification
The assertions assume a memory side that returns `mem_rsp_valid` only for a request it has accepted. They also assume `start` is a single-cycle pulse whose operand inputs are valid in that cycle. The bench's memory model answers exactly one response one cycle after each accepted request. It stalls acceptance on a fixed pattern, which covers the hold rule of R4. The bench drives every operand only on the falling edge, and a second `start` appears only in the busy window of the R10 test.

// File: rtl/ldrep_pkg.sv
package ldrep_pkg;
  localparam int RIDX_W = 5;
  localparam int GIDX_W = 4;
  localparam int MAX_REG = 31;
  localparam logic [GIDX_W-1:0] GR_SP = 4'd13;
  localparam logic [GIDX_W-1:0] GR_PC = 4'd15;

  typedef enum logic [1:0] {WB_NONE = 2'd0, WB_IMM = 2'd1, WB_OFF = 2'd2, WB_BAD = 2'd3} wb_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_REQ, ST_RSP, ST_WR, ST_FIN
  } seq_state_e;

  typedef struct packed {
    logic [1:0]        cnt;
    logic [1:0]        esize;
    logic              stride;
    logic              pair;
    logic [RIDX_W-1:0] dreg;
    logic [2:0]        hint;
    wb_mode_e          wb;
    logic [GIDX_W-1:0] bidx;
    logic [GIDX_W-1:0] oidx;
  } op_cfg_t;
endpackage

// File: rtl/ldrep_decode.sv
module ldrep_decode
  import ldrep_pkg::*;
(
  input  op_cfg_t    cfg,
  input  logic [3:0] base_lo,
  output logic       illegal,
  output logic       misaligned,
  output logic [1:0] elem_lg
);
  localparam int LAST_W = RIDX_W + 2;

  logic              hint_ok;
  logic [LAST_W-1:0] span;
  logic [LAST_W-1:0] last_reg;
  logic [2:0]        align_lg;
  logic [4:0]        align_mask;

  always_comb begin
    hint_ok = (cfg.hint == 3'd0);
    unique case (cfg.cnt)
      2'd0: hint_ok = hint_ok || (cfg.esize == 2'd1 && cfg.hint == 3'd2)
                              || (cfg.esize == 2'd2 && cfg.hint == 3'd3);
      2'd1: hint_ok = hint_ok || (cfg.esize != 2'd3 && cfg.hint == {1'b0, cfg.esize} + 3'd1);
      2'd2: hint_ok = hint_ok;
      default: hint_ok = hint_ok || (cfg.esize == 2'd0 && cfg.hint == 3'd3)
                                 || (cfg.esize == 2'd1 && cfg.hint == 3'd4)
                                 || (cfg.esize == 2'd2 && (cfg.hint == 3'd4 || cfg.hint == 3'd5));
    endcase
  end

  always_comb begin
    if (cfg.pair) span = LAST_W'(1);
    else if (cfg.stride) span = LAST_W'({cfg.cnt, 1'b0});
    else span = LAST_W'(cfg.cnt);
    last_reg = LAST_W'(cfg.dreg) + span;
  end

  assign illegal = (cfg.esize == 2'd3) || (cfg.wb == WB_BAD) || (cfg.bidx == GR_PC)
                || (cfg.wb == WB_OFF && (cfg.oidx == GR_SP || cfg.oidx == GR_PC))
                || (cfg.pair && cfg.cnt != 2'd0)
                || (last_reg > LAST_W'(MAX_REG))
                || !hint_ok;

  assign align_lg   = (cfg.hint == 3'd0) ? {1'b0, cfg.esize} : cfg.hint - 3'd1;
  assign align_mask = (5'd1 << align_lg) - 5'd1;
  assign misaligned = |(base_lo & align_mask[3:0]);
  assign elem_lg    = cfg.esize;
endmodule

// File: rtl/ldrep_replicate.sv
module ldrep_replicate #(
  parameter int REG_W = 64,
  localparam int LANES = REG_W / 8
) (
  input  logic [31:0]      elem,
  input  logic [1:0]       esize,
  output logic [REG_W-1:0] lanes
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_comb begin
      unique case (esize)
        2'd0:    lanes[j*8 +: 8] = elem[7:0];
        2'd1:    lanes[j*8 +: 8] = elem[(j % 2)*8 +: 8];
        default: lanes[j*8 +: 8] = elem[(j % 4)*8 +: 8];
      endcase
    end
  end

  always_comb begin
    if (esize == 2'd0)
      AST_LANE_COPY: assert (lanes[REG_W-1 -: 8] == lanes[7:0]); // R5
  end
endmodule

// File: rtl/ldrep_unit.sv
module ldrep_unit
  import ldrep_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op_count,
  input  logic [1:0]        op_esize,
  input  logic              op_stride,
  input  logic              op_pair,
  input  logic [4:0]        op_dreg,
  input  logic [2:0]        op_hint,
  input  logic [1:0]        op_wb,
  input  logic [3:0]        base_idx,
  input  logic [3:0]        off_idx,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] off_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [1:0]        mem_req_size,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  output logic              wr_valid,
  output logic [4:0]        wr_idx,
  output logic [REG_W-1:0]  wr_data,
  output logic              done,
  output logic              illegal,
  output logic              align_fault,
  output logic              base_wb_valid,
  output logic [ADDR_W-1:0] base_out
);
  seq_state_e        st_q;
  op_cfg_t           cfg_q;
  logic [ADDR_W-1:0] base_q, off_q, base_out_q;
  logic [31:0]       elem_q;
  logic [1:0]        k_q;
  logic              w_q;
  logic              dec_ill, dec_mis;
  logic [1:0]        elg;
  logic [4:0]        step;
  logic              last_write;

  ldrep_decode u_dec (
    .cfg(cfg_q), .base_lo(base_q[3:0]),
    .illegal(dec_ill), .misaligned(dec_mis), .elem_lg(elg)
  );

  ldrep_replicate #(.REG_W(REG_W)) u_rep (
    .elem(elem_q), .esize(cfg_q.esize), .lanes(wr_data)
  );

  assign last_write = !(cfg_q.pair && !w_q) && (k_q == cfg_q.cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cfg_q      <= '0;
      base_q     <= '0;
      off_q      <= '0;
      base_out_q <= '0;
      elem_q     <= '0;
      k_q        <= '0;
      w_q        <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          cfg_q  <= '{cnt: op_count, esize: op_esize, stride: op_stride, pair: op_pair,
                     dreg: op_dreg, hint: op_hint, wb: wb_mode_e'(op_wb),
                     bidx: base_idx, oidx: off_idx};
          base_q <= base_addr;
          off_q  <= off_val;
          k_q    <= '0;
          w_q    <= 1'b0;
          st_q   <= ST_EVAL;
        end
        ST_EVAL: st_q <= (dec_ill || dec_mis) ? ST_IDLE : ST_REQ;
        ST_REQ:  if (mem_req_ready) st_q <= ST_RSP;
        ST_RSP:  if (mem_rsp_valid) begin
          elem_q <= mem_rsp_data;
          st_q   <= ST_WR;
        end
        ST_WR: begin
          if (cfg_q.pair && !w_q) begin
            w_q <= 1'b1;
          end else if (last_write) begin
            st_q <= ST_FIN;
            if (cfg_q.wb == WB_IMM)
              base_out_q <= base_q + (ADDR_W'({1'b0, cfg_q.cnt} + 3'd1) << elg);
            else if (cfg_q.wb == WB_OFF)
              base_out_q <= base_q + off_q;
          end else begin
            k_q  <= k_q + 2'd1;
            st_q <= ST_REQ;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (cfg_q.pair) step = {4'b0, w_q};
    else if (cfg_q.stride) step = {2'b0, k_q, 1'b0};
    else step = {3'b0, k_q};
  end

  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = base_q + (ADDR_W'(k_q) << elg);
  assign mem_req_size  = elg;
  assign mem_rsp_ready = (st_q == ST_RSP);
  assign wr_valid      = (st_q == ST_WR);
  assign wr_idx        = cfg_q.dreg + step;
  assign illegal       = (st_q == ST_EVAL) && dec_ill;
  assign align_fault   = (st_q == ST_EVAL) && !dec_ill && dec_mis;
  assign done          = (st_q == ST_FIN) || illegal || align_fault;
  assign base_wb_valid = (st_q == ST_FIN) && (cfg_q.wb != WB_NONE);
  assign base_out      = base_out_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal || align_fault) |=> !mem_req_valid && !wr_valid); // R1
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({illegal, align_fault, base_wb_valid})); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_WB_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    base_wb_valid |-> done); // R7
  AST_NO_WB_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !base_wb_valid) |-> $stable(base_out)); // R9
endmodule

// File: tb/test_ldrep_unit.sv
module test_ldrep_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic start = 0, op_stride = 0, op_pair = 0;
  logic [1:0] op_count = 0, op_esize = 0, op_wb = 0;
  logic [4:0] op_dreg = 0;
  logic [2:0] op_hint = 0;
  logic [3:0] base_idx = 0, off_idx = 0;
  logic [31:0] base_addr = 0, off_val = 0;
  logic mem_req_valid, mem_req_ready, mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_req_addr, mem_rsp_data, base_out;
  logic [1:0] mem_req_size;
  logic wr_valid, done, illegal, align_fault, base_wb_valid;
  logic [4:0] wr_idx;
  logic [63:0] wr_data;

  ldrep_unit i_ldrep_unit (.*);

  int n_chk = 0, n_bad = 0, cyc_total = 0;
  logic [31:0] exp_base = 0;

  function automatic logic [7:0] mb(logic [31:0] a);
    return a[7:0] * 8'd7 + 8'h13;
  endfunction

  // memory model: one response the cycle after acceptance, acceptance stalls on a pattern
  logic pend = 0;
  logic [31:0] paddr = 0;
  int rdy_cnt = 0;
  logic rdy_q = 0;
  assign mem_req_ready = rdy_q;
  assign mem_rsp_valid = pend;
  assign mem_rsp_data  = {mb(paddr + 3), mb(paddr + 2), mb(paddr + 1), mb(paddr)};
  always @(negedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    rdy_q   <= (rdy_cnt % 3) != 0;
  end
  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      pend  <= 1'b1;
      paddr <= mem_req_addr;
    end else if (mem_rsp_valid && mem_rsp_ready) pend <= 1'b0;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc_total);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit hint_legal(int n, int es, int hn);
    if (hn == 0) return 1;
    case (n)
      1: return (es == 1 && hn == 2) || (es == 2 && hn == 3);
      2: return hn == es + 1;
      3: return 0;
      default: return (es == 0 && hn == 3) || (es == 1 && hn == 4) || (es == 2 && (hn == 4 || hn == 5));
    endcase
  endfunction

  task automatic run_op(int n, int es, int st, int d, int pr, int hn, logic [31:0] base,
                        int wb, int bi, int oi, logic [31:0] off, bit poke);
    int eb = 1 << es;
    int nregs = pr ? 2 : n;
    int last = d + (pr ? 1 : (n - 1) * (st ? 2 : 1));
    int req = (hn != 0) ? (1 << (hn - 1)) : eb;
    bit eill = (es == 3) || (wb == 3) || (bi == 15) || (wb == 2 && (oi == 13 || oi == 15))
            || (pr && n != 1) || (last > 31) || !hint_legal(n, es, hn);
    bit efault = !eill && (base % req) != 0;
    logic [4:0]  gi[8];
    logic [63:0] gd[8];
    int nw = 0, cyc = 0, nreq = 0;
    bit saw_done = 0, f_ill = 0, f_al = 0, f_wbv = 0;
    logic [31:0] f_base = 0;
    @(negedge clk);
    op_count = 2'(n - 1); op_esize = 2'(es); op_stride = st[0]; op_pair = pr[0];
    op_dreg = 5'(d); op_hint = 3'(hn); op_wb = 2'(wb); base_idx = 4'(bi); off_idx = 4'(oi);
    base_addr = base; off_val = off; start = 1;
    @(negedge clk);
    start = 0;
    while (cyc < 80) begin
      if (wr_valid && nw < 8) begin gi[nw] = wr_idx; gd[nw] = wr_data; nw++; end
      else if (wr_valid) nw++;
      if (mem_req_valid) nreq++;
      if (done) begin
        saw_done = 1; f_ill = illegal; f_al = align_fault; f_wbv = base_wb_valid; f_base = base_out;
        break;
      end
      if (poke && cyc == 1) begin op_dreg = 5'd20; op_count = 2'd0; start = 1; end
      if (poke && cyc == 2) start = 0;
      @(negedge clk);
      cyc++;
    end
    chk(saw_done, "R11", "done seen", 64'(saw_done), 1);
    if (eill) begin
      chk(f_ill && cyc == 0, "R1", "illegal in cycle after start", 64'(cyc), 0);
      chk(nreq == 0 && nw == 0, "R1", "no access when illegal", 64'(nreq + nw), 0);
      chk(!f_wbv && f_base == exp_base, "R9", "base kept on illegal", 64'(f_base), 64'(exp_base));
    end else if (efault) begin
      chk(f_al && !f_ill && cyc == 0, "R3", "align fault flagged", 64'({f_ill, f_al}), 1);
      chk(nreq == 0 && nw == 0, "R3", "no access on fault", 64'(nreq + nw), 0);
      chk(!f_wbv && f_base == exp_base, "R9", "base kept on fault", 64'(f_base), 64'(exp_base));
    end else begin
      chk(!f_ill && !f_al, "R2", "legal hint accepted", 64'({f_ill, f_al}), 0);
      chk(nw == nregs, "R6", "write count", 64'(nw), 64'(nregs));
      for (int w = 0; w < nregs && w < nw; w++) begin
        int e = pr ? 0 : w;
        logic [31:0] ea = base + 32'(e * eb);
        logic [63:0] ed;
        int ei = pr ? d + w : d + e * (st ? 2 : 1);
        for (int j = 0; j < 8; j++) ed[j*8 +: 8] = mb(ea + 32'(j % eb));
        chk(gi[w] == 5'(ei), "R6", "write index", 64'(gi[w]), 64'(ei));
        chk(gd[w] == ed, "R5", "replicated data", gd[w], ed);
      end
      if (wb == 1) exp_base = base + 32'(n * eb);
      else if (wb == 2) exp_base = base + off;
      chk(f_wbv == (wb != 0), "R7", "base_wb_valid", 64'(f_wbv), 64'(wb != 0));
      chk(f_base == exp_base, wb == 0 ? "R9" : (wb == 1 ? "R7" : "R8"), "base_out",
          64'(f_base), 64'(exp_base));
    end
    @(negedge clk);
    chk(!done, "R11", "done one cycle", 64'(done), 0);
  endtask

  // request-side check: address and size of each accepted request (R4, R8)
  int rq_k = 0;
  logic [31:0] rq_base = 0;
  int rq_eb = 1;
  bit rq_on = 0;
  always @(negedge clk) begin
    if (start && !rq_on) begin rq_on = 1; rq_k = 0; rq_base = base_addr; rq_eb = 1 << op_esize; end
    if (done) rq_on = 0;
    if (rq_on && mem_req_valid && mem_req_ready) begin
      chk(mem_req_addr == rq_base + 32'(rq_k * rq_eb), "R4", "request address",
          64'(mem_req_addr), 64'(rq_base + 32'(rq_k * rq_eb)));
      chk((1 << mem_req_size) == rq_eb, "R4", "request size", 64'(mem_req_size), 64'(rq_eb));
      rq_k++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !illegal && !align_fault && !wr_valid && !mem_req_valid && !base_wb_valid
        && base_out == 0, "R11", "reset outputs", 64'(base_out), 0);
    rst_n = 1;
    for (int n = 1; n <= 4; n++)
      for (int es = 0; es <= 3; es++)
        for (int st = 0; st <= 1; st++)
          for (int pr = 0; pr <= 1; pr++)
            for (int hn = 0; hn <= 7; hn++)
              for (int wb = 0; wb <= 3; wb++)
                run_op(n, es, st, 24 + (n * 3 + es) % 8, pr, hn,
                       32'h200 + 32'((n * 5 + es * 3 + hn + wb * 7 + pr) % 16),
                       wb, 3, 5, 32'h40 + 32'(n), 0);
    run_op(2, 1, 0, 4, 0, 0, 32'h400, 1, 15, 5, 32'h10, 0);  // R1 base is PC
    run_op(2, 1, 0, 4, 0, 0, 32'h400, 2, 3, 13, 32'h10, 0);  // R1 offset is SP
    run_op(2, 1, 0, 4, 0, 0, 32'h400, 2, 3, 15, 32'h10, 0);  // R1 offset is PC
    run_op(2, 1, 0, 4, 0, 0, 32'h400, 1, 3, 13, 32'h10, 0);  // R7 SP offset unused
    run_op(4, 2, 1, 2, 0, 5, 32'h500, 2, 3, 7, 32'hFFFF_FFF0, 0); // R8 wrap
    run_op(4, 1, 1, 2, 0, 0, 32'h300, 1, 3, 5, 32'h0, 1);    // R10 start while busy
    run_op(1, 2, 0, 30, 1, 3, 32'h604, 0, 3, 5, 32'h0, 1);   // R10 pair + busy start
    summary();
    $finish;
  end
endmodule